// File: doc/BRIEF.md
# Firmware ROM Sector Access Guard

This block sits beside the firmware ROM decoder and rules on every access to the ROM window. The top megabyte of the address space is split into sixteen 64 KB sectors. Each sector has a four-bit lock nibble. A seventeenth nibble covers the remaining ROM span from FFC0_0000h to FFEF_FFFFh. For each request the block returns a combinational allow/deny.

Two bits in every nibble can only ever be raised. They grade who may still change the read and write locks: anyone, only system-management code, or nobody until the next reset. A global register-lock bit can further confine all lock-register writes to system-management mode. The block follows that mode by decoding the data words of bus special cycles. Before the lookup, it folds legacy firmware addresses in the low megabyte onto the top megabyte.

Top module: `rom_guard`

## Requirements
- R1: After reset, all seventeen nibbles and the register-lock bit read 0, the block is out of system-management mode, and `cfg_wr_ok_o` is 1.
- R2: Nibble bit2 (SMM-gate) and bit3 (full-lock), and register 17 bit0 (register lock), are write-1-only. A permitted write ORs the written value into them, and writing 0 leaves them set.
- R3: While a nibble's full-lock bit, as held before the write, is 1, its bits [1:0] cannot change in any mode. A single write that sets full-lock still updates [1:0].
- R4: While a nibble's SMM-gate bit, as held before the write, is 1 and full-lock is 0, its bits [1:0] change only when the write happens in system-management mode.
- R5: A special cycle with data 0005_0002h enters system-management mode, and 0006_0002h leaves it. Any other data word leaves the mode unchanged. The new mode applies from the next cycle.
- R6: Addresses 000C_0000h–000F_FFFFh are mapped to FFFC_0000h–FFFF_FFFFh (upper 12 bits forced to FFFh) before the lookup. Other low addresses are not remapped.
- R7: Addresses FFF0_0000h–FFFF_FFFFh use the nibble in register 0..15 chosen by address bits [19:16].
- R8: Addresses FFC0_0000h–FFEF_FFFFh use register 16. Other addresses with the firmware flag set have no lock, so only the write-enable rule applies.
- R9: A read is denied when the selected nibble's bit0 (read lock) is 1.
- R10: A write is allowed only when `rom_we_i` is 1 and the selected nibble's bit1 (write lock) is 0.
- R11: With `acc_fw_i` low, every access is allowed regardless of the lock registers.
- R12: Register 17 bit0 is the register lock. While it is 1 and the block is not in system-management mode, writes to registers 0..17 are dropped and `cfg_wr_ok_o` is 0. Otherwise `cfg_wr_ok_o` is 1.
- R13: Register reads are combinational and always return current values. Register 16 holds the rest-of-ROM nibble. Addresses 18..31 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous bus reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register index: 0..15 sectors, 16 rest, 17 control |
| reg_wdata_i | input | 4 | Register write data |
| reg_rdata_o | output | 4 | Register read data at `reg_addr_i` |
| sc_valid_i | input | 1 | Special-cycle strobe |
| sc_data_i | input | 32 | Special-cycle data word |
| acc_addr_i | input | 32 | Access address |
| acc_wr_i | input | 1 | 1 = write access, 0 = read |
| acc_fw_i | input | 1 | Access falls in firmware space |
| rom_we_i | input | 1 | Global ROM write enable |
| acc_allow_o | output | 1 | 1 = access allowed |
| cfg_wr_ok_o | output | 1 | Writes to the neighbouring decode register currently permitted |

## Verification
Every cycle, assertions check several properties. Set gate bits never fall. A full-locked nibble and a gated nibble outside system-management mode keep their read/write bits. The register lock freezes every nibble outside that mode. The mode follows the enter word and holds without a special cycle. Writes with the global enable low or the firmware flag off get the required answer. Some behaviour is only visible in the bench scenarios: the remap and sector decode at window edges, the before-write evaluation when full-lock is set in the same write, unknown special-cycle words, and the recovery of every state to default after a mid-run reset.

// File: rtl/rom_guard_pkg.sv
package rom_guard_pkg;
  localparam int unsigned NIB_W = 4;
  localparam int unsigned B_RD  = 0;
  localparam int unsigned B_WR  = 1;
  localparam int unsigned B_GT  = 2;
  localparam int unsigned B_FL  = 3;
  localparam logic [31:0] SC_ENTER = 32'h0005_0002;
  localparam logic [31:0] SC_EXIT  = 32'h0006_0002;
  typedef logic [NIB_W-1:0] nib_t;
endpackage

// File: rtl/rom_guard_smm_tracker.sv
module rom_guard_smm_tracker #(
  parameter int unsigned SC_W = 32,
  parameter logic [SC_W-1:0] ENTER_WORD = rom_guard_pkg::SC_ENTER,
  parameter logic [SC_W-1:0] EXIT_WORD  = rom_guard_pkg::SC_EXIT
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sc_valid_i,
  input  logic [SC_W-1:0] sc_data_i,
  output logic            smm_o
);
  logic smm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smm_q <= 1'b0;
    else if (sc_valid_i) begin
      if (sc_data_i == ENTER_WORD)     smm_q <= 1'b1;
      else if (sc_data_i == EXIT_WORD) smm_q <= 1'b0;
    end
  end

  assign smm_o = smm_q;

  p_smm_enter_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_valid_i && sc_data_i == ENTER_WORD) |=> smm_o);
  p_smm_exit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_valid_i && sc_data_i == EXIT_WORD) |=> !smm_o);
  p_smm_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sc_valid_i |=> $stable(smm_o));
endmodule

// File: rtl/rom_guard_lock_regs.sv
module rom_guard_lock_regs
  import rom_guard_pkg::*;
#(
  parameter int unsigned N_SECT = 16,
  parameter int unsigned RA_W   = 5,
  localparam int unsigned NUM_NIB  = N_SECT + 1,
  localparam int unsigned CTRL_IDX = N_SECT + 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         smm_i,
  input  logic                         reg_we_i,
  input  logic [RA_W-1:0]              reg_addr_i,
  input  logic [NIB_W-1:0]             reg_wdata_i,
  output logic [NIB_W-1:0]             reg_rdata_o,
  output logic [NUM_NIB-1:0][NIB_W-1:0] nib_o,
  output logic                         wr_gate_o
);
  nib_t nib_q [NUM_NIB];
  logic reg_lock_q;
  logic wr_gate;

  assign wr_gate   = !reg_lock_q || smm_i;
  assign wr_gate_o = wr_gate;

  for (genvar i = 0; i < NUM_NIB; i++) begin : g_nib
    logic hit;
    logic rw_open;
    assign hit     = reg_we_i && wr_gate && (reg_addr_i == RA_W'(i));
    // gating judged on bits held before this write
    assign rw_open = !nib_q[i][B_FL] && (!nib_q[i][B_GT] || smm_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) nib_q[i] <= '0;
      else if (hit) begin
        nib_q[i][B_FL] <= nib_q[i][B_FL] | reg_wdata_i[B_FL];
        nib_q[i][B_GT] <= nib_q[i][B_GT] | reg_wdata_i[B_GT];
        if (rw_open) begin
          nib_q[i][B_RD] <= reg_wdata_i[B_RD];
          nib_q[i][B_WR] <= reg_wdata_i[B_WR];
        end
      end
    end

    assign nib_o[i] = nib_q[i];

    p_sticky_fl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      nib_q[i][B_FL] |=> nib_q[i][B_FL]);
    p_sticky_gt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      nib_q[i][B_GT] |=> nib_q[i][B_GT]);
    p_full_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      nib_q[i][B_FL] |=> $stable(nib_q[i][B_WR:B_RD]));
    p_gate_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (nib_q[i][B_GT] && !smm_i) |=> $stable(nib_q[i][B_WR:B_RD]));
    p_reg_lock_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_lock_q && !smm_i) |=> $stable(nib_q[i]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reg_lock_q <= 1'b0;
    else if (reg_we_i && wr_gate && reg_addr_i == RA_W'(CTRL_IDX))
      reg_lock_q <= reg_lock_q | reg_wdata_i[0];
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int i = 0; i < NUM_NIB; i++)
      if (reg_addr_i == RA_W'(i)) reg_rdata_o = nib_q[i];
    if (reg_addr_i == RA_W'(CTRL_IDX)) reg_rdata_o = {{(NIB_W-1){1'b0}}, reg_lock_q};
  end

  p_lock_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_lock_q |=> reg_lock_q);
endmodule

// File: rtl/rom_guard_access_check.sv
module rom_guard_access_check
  import rom_guard_pkg::*;
#(
  parameter int unsigned A_W        = 32,
  parameter int unsigned SECT_LOG2  = 4,
  parameter int unsigned SECT_SZ_LG = 16,
  parameter logic [A_W-1:0] REST_LO = 32'hFFC0_0000,
  parameter logic [A_W-1:0] REST_HI = 32'hFFEF_FFFF,
  localparam int unsigned N_SECT  = 1 << SECT_LOG2,
  localparam int unsigned WIN_LG  = SECT_LOG2 + SECT_SZ_LG,
  localparam int unsigned NUM_NIB = N_SECT + 1
) (
  input  logic [A_W-1:0]                acc_addr_i,
  input  logic                          acc_wr_i,
  input  logic                          acc_fw_i,
  input  logic                          rom_we_i,
  input  logic [NUM_NIB-1:0][NIB_W-1:0] nib_i,
  output logic                          acc_allow_o
);
  logic [A_W-1:0]       eff;
  logic                 legacy, in_top, in_rest;
  logic [SECT_LOG2-1:0] idx;
  nib_t                 sel;

  // low legacy window: top quarter of the first window-sized block
  assign legacy  = (acc_addr_i[A_W-1:WIN_LG] == '0) && (&acc_addr_i[WIN_LG-1:WIN_LG-2]);
  assign eff     = legacy ? {{(A_W-WIN_LG){1'b1}}, acc_addr_i[WIN_LG-1:0]} : acc_addr_i;
  assign in_top  = &eff[A_W-1:WIN_LG];
  assign idx     = eff[WIN_LG-1:SECT_SZ_LG];
  assign in_rest = (eff >= REST_LO) && (eff <= REST_HI);

  always_comb begin
    if (in_top)       sel = nib_i[idx];
    else if (in_rest) sel = nib_i[N_SECT];
    else              sel = '0;
  end

  always_comb begin
    if (!acc_fw_i)     acc_allow_o = 1'b1;
    else if (acc_wr_i) acc_allow_o = rom_we_i && !sel[B_WR];
    else               acc_allow_o = !sel[B_RD];
  end

  always_comb begin
    if (acc_fw_i == 1'b0)
      p_fw_off_r11: assert (acc_allow_o == 1'b1);
    if (acc_fw_i == 1'b1 && acc_wr_i == 1'b1 && rom_we_i == 1'b0)
      p_wr_no_we_r10: assert (acc_allow_o == 1'b0);
  end
endmodule

// File: rtl/rom_guard.sv
module rom_guard
  import rom_guard_pkg::*;
#(
  parameter int unsigned A_W        = 32,
  parameter int unsigned SECT_LOG2  = 4,
  parameter int unsigned SECT_SZ_LG = 16,
  parameter logic [A_W-1:0] REST_LO = 32'hFFC0_0000,
  parameter logic [A_W-1:0] REST_HI = 32'hFFEF_FFFF,
  localparam int unsigned N_SECT  = 1 << SECT_LOG2,
  localparam int unsigned NUM_NIB = N_SECT + 1,
  localparam int unsigned RA_W    = $clog2(N_SECT + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [RA_W-1:0]  reg_addr_i,
  input  logic [NIB_W-1:0] reg_wdata_i,
  output logic [NIB_W-1:0] reg_rdata_o,
  input  logic             sc_valid_i,
  input  logic [31:0]      sc_data_i,
  input  logic [A_W-1:0]   acc_addr_i,
  input  logic             acc_wr_i,
  input  logic             acc_fw_i,
  input  logic             rom_we_i,
  output logic             acc_allow_o,
  output logic             cfg_wr_ok_o
);
  logic smm;
  logic [NUM_NIB-1:0][NIB_W-1:0] nib;

  rom_guard_smm_tracker #(.SC_W(32)) u_smm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sc_valid_i(sc_valid_i), .sc_data_i(sc_data_i), .smm_o(smm)
  );

  rom_guard_lock_regs #(.N_SECT(N_SECT), .RA_W(RA_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .smm_i(smm),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .nib_o(nib), .wr_gate_o(cfg_wr_ok_o)
  );

  rom_guard_access_check #(
    .A_W(A_W), .SECT_LOG2(SECT_LOG2), .SECT_SZ_LG(SECT_SZ_LG),
    .REST_LO(REST_LO), .REST_HI(REST_HI)
  ) u_chk (
    .acc_addr_i(acc_addr_i), .acc_wr_i(acc_wr_i), .acc_fw_i(acc_fw_i),
    .rom_we_i(rom_we_i), .nib_i(nib), .acc_allow_o(acc_allow_o)
  );
endmodule

// File: tb/rom_guard_test.sv
module rom_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] K_WR = 2'd0, K_SC = 2'd1, K_ACC = 2'd2, K_RD = 2'd3;

  typedef struct packed {
    logic [1:0]  k;
    logic [31:0] a;
    logic [3:0]  d;
    logic        wr;
    logic        fw;
    logic        we;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 53;
  localparam vec_t TBL [NV] = '{
    '{K_RD,  32'd0,          4'd0, 1'b0,1'b0,1'b0, 8'd1},   // R1
    '{K_RD,  32'd17,         4'd0, 1'b0,1'b0,1'b0, 8'd1},   // R1
    '{K_ACC, 32'hFFF0_0000,  4'd1, 1'b0,1'b1,1'b0, 8'd7},   // R7
    '{K_WR,  32'd0,          4'd1, 1'b0,1'b0,1'b0, 8'd0},
    '{K_ACC, 32'hFFF0_1234,  4'd0, 1'b0,1'b1,1'b0, 8'd9},   // R9
    '{K_ACC, 32'hFFF1_0000,  4'd1, 1'b0,1'b1,1'b0, 8'd7},   // R7
    '{K_WR,  32'd15,         4'd2, 1'b0,1'b0,1'b0, 8'd0},
    '{K_ACC, 32'hFFFF_0000,  4'd0, 1'b1,1'b1,1'b1, 8'd10},  // R10
    '{K_ACC, 32'h000F_0000,  4'd0, 1'b1,1'b1,1'b1, 8'd6},   // R6
    '{K_ACC, 32'h000F_0000,  4'd1, 1'b0,1'b1,1'b1, 8'd6},   // R6
    '{K_ACC, 32'hFFFE_0000,  4'd1, 1'b1,1'b1,1'b1, 8'd10},  // R10
    '{K_ACC, 32'hFFFE_0000,  4'd0, 1'b1,1'b1,1'b0, 8'd10},  // R10
    '{K_WR,  32'd12,         4'd1, 1'b0,1'b0,1'b0, 8'd0},
    '{K_ACC, 32'h000C_0000,  4'd0, 1'b0,1'b1,1'b0, 8'd6},   // R6
    '{K_ACC, 32'h000B_FFFF,  4'd1, 1'b0,1'b1,1'b0, 8'd6},   // R6
    '{K_WR,  32'd16,         4'd3, 1'b0,1'b0,1'b0, 8'd0},
    '{K_ACC, 32'hFFC0_0000,  4'd0, 1'b0,1'b1,1'b0, 8'd8},   // R8
    '{K_ACC, 32'hFFEF_FFFF,  4'd0, 1'b1,1'b1,1'b1, 8'd8},   // R8
    '{K_ACC, 32'hFFBF_FFFF,  4'd1, 1'b1,1'b1,1'b1, 8'd8},   // R8
    '{K_ACC, 32'hFFF0_0000,  4'd1, 1'b0,1'b0,1'b0, 8'd11},  // R11
    '{K_WR,  32'd1,          4'd4, 1'b0,1'b0,1'b0, 8'd0},
    '{K_RD,  32'd1,          4'd4, 1'b0,1'b0,1'b0, 8'd2},   // R2
    '{K_WR,  32'd1,          4'd1, 1'b0,1'b0,1'b0, 8'd0},
    '{K_RD,  32'd1,          4'd4, 1'b0,1'b0,1'b0, 8'd4},   // R4
    '{K_WR,  32'd1,          4'd0, 1'b0,1'b0,1'b0, 8'd0},
    '{K_RD,  32'd1,          4'd4, 1'b0,1'b0,1'b0, 8'd2},   // R2
    '{K_SC,  32'h0005_0002,  4'd0, 1'b0,1'b0,1'b0, 8'd0},
    '{K_WR,  32'd1,          4'd5, 1'b0,1'b0,1'b0, 8'd0},
    '{K_RD,  32'd1,          4'd5, 1'b0,1'b0,1'b0, 8'd4},   // R4
    '{K_SC,  32'h1234_5678,  4'd0, 1'b0,1'b0,1'b0, 8'd0},
    '{K_WR,  32'd1,          4'd4, 1'b0,1'b0,1'b0, 8'd0},
    '{K_RD,  32'd1,          4'd4, 1'b0,1'b0,1'b0, 8'd5},   // R5
    '{K_SC,  32'h0006_0002,  4'd0, 1'b0,1'b0,1'b0, 8'd0},
    '{K_WR,  32'd1,          4'd1, 1'b0,1'b0,1'b0, 8'd0},
    '{K_RD,  32'd1,          4'd4, 1'b0,1'b0,1'b0, 8'd5},   // R5
    '{K_WR,  32'd2,          4'd9, 1'b0,1'b0,1'b0, 8'd0},
    '{K_RD,  32'd2,          4'd9, 1'b0,1'b0,1'b0, 8'd3},   // R3
    '{K_WR,  32'd2,          4'd8, 1'b0,1'b0,1'b0, 8'd0},
    '{K_RD,  32'd2,          4'd9, 1'b0,1'b0,1'b0, 8'd3},   // R3
    '{K_SC,  32'h0005_0002,  4'd0, 1'b0,1'b0,1'b0, 8'd0},
    '{K_WR,  32'd2,          4'd8, 1'b0,1'b0,1'b0, 8'd0},
    '{K_RD,  32'd2,          4'd9, 1'b0,1'b0,1'b0, 8'd3},   // R3
    '{K_SC,  32'h0006_0002,  4'd0, 1'b0,1'b0,1'b0, 8'd0},
    '{K_WR,  32'd17,         4'd1, 1'b0,1'b0,1'b0, 8'd0},
    '{K_RD,  32'd17,         4'd1, 1'b0,1'b0,1'b0, 8'd12},  // R12
    '{K_WR,  32'd3,          4'd2, 1'b0,1'b0,1'b0, 8'd0},
    '{K_RD,  32'd3,          4'd0, 1'b0,1'b0,1'b0, 8'd12},  // R12
    '{K_SC,  32'h0005_0002,  4'd0, 1'b0,1'b0,1'b0, 8'd0},
    '{K_WR,  32'd3,          4'd2, 1'b0,1'b0,1'b0, 8'd0},
    '{K_RD,  32'd3,          4'd2, 1'b0,1'b0,1'b0, 8'd12},  // R12
    '{K_SC,  32'h0006_0002,  4'd0, 1'b0,1'b0,1'b0, 8'd0},
    '{K_RD,  32'd20,         4'd0, 1'b0,1'b0,1'b0, 8'd13},  // R13
    '{K_RD,  32'd16,         4'd3, 1'b0,1'b0,1'b0, 8'd13}   // R13
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [4:0]  reg_addr_i = '0;
  logic [3:0]  reg_wdata_i = '0;
  logic [3:0]  reg_rdata_o;
  logic        sc_valid_i = 1'b0;
  logic [31:0] sc_data_i = '0;
  logic [31:0] acc_addr_i = '0;
  logic        acc_wr_i = 1'b0;
  logic        acc_fw_i = 1'b0;
  logic        rom_we_i = 1'b0;
  logic        acc_allow_o;
  logic        cfg_wr_ok_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rom_guard uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .sc_valid_i(sc_valid_i), .sc_data_i(sc_data_i),
    .acc_addr_i(acc_addr_i), .acc_wr_i(acc_wr_i), .acc_fw_i(acc_fw_i),
    .rom_we_i(rom_we_i), .acc_allow_o(acc_allow_o), .cfg_wr_ok_o(cfg_wr_ok_o)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic do_wr(input logic [4:0] a, input logic [3:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic do_sc(input logic [31:0] w);
    @(negedge clk_i);
    sc_data_i = w; sc_valid_i = 1'b1;
    @(negedge clk_i);
    sc_valid_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [3:0] e, input string rq);
    @(negedge clk_i);
    reg_addr_i = a;
    #1;
    check(rq, 32'(reg_rdata_o), 32'(e));
  endtask

  task automatic acc_chk(input logic [31:0] a, input logic wr, input logic fw,
                         input logic we, input logic e, input string rq);
    @(negedge clk_i);
    acc_addr_i = a; acc_wr_i = wr; acc_fw_i = fw; rom_we_i = we;
    #1;
    check(rq, 32'(acc_allow_o), 32'(e));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    check("R1", 32'(cfg_wr_ok_o), 32'd1);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", TBL[i].rq);
      case (TBL[i].k)
        K_WR:  do_wr(TBL[i].a[4:0], TBL[i].d);
        K_SC:  do_sc(TBL[i].a);
        K_ACC: acc_chk(TBL[i].a, TBL[i].wr, TBL[i].fw, TBL[i].we, TBL[i].d[0], tag);
        default: rd_chk(TBL[i].a[4:0], TBL[i].d, tag);
      endcase
    end

    // R12: decode-register permit follows lock and mode
    @(negedge clk_i); #1;
    check("R12", 32'(cfg_wr_ok_o), 32'd0);
    do_sc(32'h0005_0002);
    #1;
    check("R12", 32'(cfg_wr_ok_o), 32'd1);

    // R1: mid-run reset returns all state to defaults
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    rd_chk(5'd17, 4'd0, "R1");
    rd_chk(5'd2, 4'd0, "R1");
    rd_chk(5'd16, 4'd0, "R1");
    check("R1", 32'(cfg_wr_ok_o), 32'd1);
    // R1: mode cleared, so gated nibble rejects rw update
    do_wr(5'd1, 4'd4);
    do_wr(5'd1, 4'd5);
    rd_chk(5'd1, 4'd4, "R1");
    acc_chk(32'hFFF0_0000, 1'b0, 1'b1, 1'b0, 1'b1, "R9");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule